// File: doc/BRIEF.md
# Memory Range Scanner with Arbitration Modes

This block walks a word-addressed memory range from a low pointer up to a high pointer. It hands every fetched word, in ascending order, to an external CRC engine over a one-word valid/ready handshake. It shares the memory with a CPU under one of four access policies, selected in a control register:

- **Concurrent:** takes idle CPU cycles and stalls the CPU only while it holds the memory.
- **Burst:** stalls the CPU for the whole range.
- **Peek:** takes idle CPU cycles and never stalls.
- **Trigger:** fetches one word per rising edge of an external trigger.

An interrupt-management bit decides, per policy, whether scanning waits for interrupt service or interrupts are held off by the scan.

Software programs the low and high pointers, enables the CRC engine, and then sets the go bit. The go bit stays set while the scan runs. Hardware clears it when the range is used up, when the CRC engine stops, or when the low pointer leaves valid memory. A scan that cannot start shows up as a set abort flag and a go bit that does not stick.

Top module: `memScanner`

## Requirements
- R1: After reset the control readback is 0x40: only the abort flag is set. No memory request, CRC valid or CPU stall is asserted.
- R2: Control layout. Bits [1:0] hold the access mode (00 concurrent, 01 burst, 10 peek, 11 trigger). Bit 2 is the interrupt-management bit, bit 3 is go and bit 4 is enable; these five bits are written through the 5-bit write port. Bit 5 is busy and bit 6 is abort, both read-only.
- R3: The scan presents the words at addresses low..high once each, in ascending order, with the memory data. The low pointer rises by one per accepted word. Once the range is used up and no data cycle is open, hardware clears go and busy, and the low pointer reads high+1. An empty range (low > high) fetches nothing.
- R4: Abort reads 1 one cycle after CRC enable or CRC go is low, or after the low pointer is at or beyond MEM_WORDS. Otherwise it reads 0. Writing go=1 under that condition leaves go at 0, and no word is fetched.
- R5: When CRC go falls, hardware clears go and no further fetch starts.
- R6: In concurrent mode a fetch starts only in a cycle where the CPU is not using memory. The CPU stall equals the memory request.
- R7: In burst mode the CPU stall stays high while enabled and go (unless paused), and fetching proceeds even when the CPU wants memory.
- R8: In peek mode the CPU stall never asserts, and no memory request is made while the CPU is using memory.
- R9: In trigger mode exactly one word is fetched per rising edge of the trigger input, and none without an edge.
- R10: With the interrupt-management bit at 1 (all modes but peek), no fetch starts while an interrupt is in service. Scanning resumes afterwards.
- R11: With the interrupt-management bit at 0, the interrupt-hold output equals interrupt-pending. In concurrent and trigger modes this applies only while a memory request is up. In burst mode it applies for as long as go is set. In peek mode the hold is never raised.
- R12: Clearing enable pauses scanning and leaves go, mode, the interrupt-management bit and both pointers unchanged. Setting enable again resumes the scan.
- R13: While CRC valid is high and ready is low, the CRC data holds steady and the low pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlWrData | input | 5 | Control write data {enable, go, intMode, mode[1:0]} |
| lowWr | input | 1 | Low pointer write strobe |
| highWr | input | 1 | High pointer write strobe |
| addrWrData | input | AW | Pointer write data |
| ctrlRd | output | 7 | Control readback {abort, busy, enable, go, intMode, mode} |
| lowAddrRd | output | AW | Current low pointer |
| highAddrRd | output | AW | High pointer |
| crcEn | input | 1 | CRC engine enabled |
| crcGo | input | 1 | CRC engine running |
| trigIn | input | 1 | External fetch trigger |
| memReq | output | 1 | Memory read request |
| memAddr | output | AW | Memory read address |
| memGnt | input | 1 | Memory grant, read data valid |
| memRdata | input | DW | Memory read data |
| cpuMemBusy | input | 1 | CPU uses memory this cycle |
| cpuStall | output | 1 | Hold the CPU off memory |
| irqPending | input | 1 | Interrupt request pending |
| irqInService | input | 1 | Interrupt being serviced |
| irqHold | output | 1 | Hold off interrupt entry |
| crcValid | output | 1 | Word offered to CRC |
| crcData | output | DW | Word offered to CRC |
| crcReady | input | 1 | CRC accepts word |

## Verification
- **Per-fetch timing:** With the bench's same-cycle memory grant and a ready CRC engine, a fetch takes three cycles: start, grant, accept. The low pointer moves on the accept edge. Go and busy drop one edge after the pointer passes high, and the abort flag follows its inputs one edge later.
- **Range completion:** The bench never samples on the edge where a change lands. It polls busy at falling edges, with a bounded wait, for completion.
- **Ordering and stall rules:** A falling-edge monitor compares each accepted CRC word with the arithmetic memory pattern and the expected address. In every cycle it checks the stall and interrupt-hold relations of the current mode.
- **Paused and refused cases:** These hold the stimulus for ten or more cycles, longer than any in-flight fetch needs to finish. The frozen counts and pointers are then read at the ports.

// File: rtl/scanPkg.sv
package scanPkg;
  typedef enum logic [1:0] {
    MODE_CONC  = 2'b00,
    MODE_BURST = 2'b01,
    MODE_PEEK  = 2'b10,
    MODE_TRIG  = 2'b11
  } scanMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_SEND = 2'd2
  } scanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic advance;
  } scanStrobe_t;

  localparam int CTRL_WR_W = 5;
  localparam int CTRL_RD_W = 7;
  localparam int MODE_LSB  = 0;
  localparam int IM_BIT    = 2;
  localparam int GO_BIT    = 3;
  localparam int EN_BIT    = 4;
  localparam int BUSY_BIT  = 5;
  localparam int ABORT_BIT = 6;
endpackage

// File: rtl/scanDatapath.sv
module scanDatapath
  import scanPkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int MEM_WORDS = 200
) (
  input  logic          clk,
  input  logic          rstN,
  input  scanStrobe_t   strobe,
  input  logic          lowWr,
  input  logic          highWr,
  input  logic [AW-1:0] addrWrData,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] lowAddr,
  output logic [AW-1:0] highAddr,
  output logic [DW-1:0] wordQ,
  output logic          lowGtHigh,
  output logic          lowInvalid
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LIMIT = CW'(MEM_WORDS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowAddr  <= '0;
      highAddr <= '0;
      wordQ    <= '0;
    end else begin
      if (lowWr) lowAddr <= addrWrData;
      else if (strobe.advance) lowAddr <= lowAddr + 1'b1;
      if (highWr) highAddr <= addrWrData;
      if (strobe.loadWord) wordQ <= memRdata;
    end
  end

  assign lowGtHigh  = lowAddr > highAddr;
  assign lowInvalid = {1'b0, lowAddr} >= LIMIT;

  // R3
  low_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(lowWr) && lowAddr != $past(lowAddr)) |-> lowAddr == AW'($past(lowAddr) + 1'b1));

  // R13
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.loadWord) |-> $stable(wordQ));
endmodule

// File: rtl/scanCtrl.sv
module scanCtrl
  import scanPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWr,
  input  logic [CTRL_WR_W-1:0] ctrlWrData,
  input  logic                 crcEn,
  input  logic                 crcGo,
  input  logic                 trigIn,
  input  logic                 cpuMemBusy,
  input  logic                 irqPending,
  input  logic                 irqInService,
  input  logic                 memGnt,
  input  logic                 crcReady,
  input  logic                 lowGtHigh,
  input  logic                 lowInvalid,
  output logic [CTRL_RD_W-1:0] ctrlRd,
  output logic                 memReq,
  output logic                 cpuStall,
  output logic                 irqHold,
  output logic                 crcValid,
  output scanStrobe_t          strobe
);
  logic       enQ, goQ, intModeQ, abortQ, trigQ, trigPending;
  scanMode_e  modeQ;
  scanState_e state;
  logic       pause, abortNow, hwClear, modeOk, startFetch, busy;

  assign pause    = intModeQ && (modeQ != MODE_PEEK) && irqInService;
  assign abortNow = !crcEn || !crcGo || lowInvalid;
  assign hwClear  = !crcGo || ((state == ST_IDLE) && (lowGtHigh || lowInvalid));

  always_comb begin
    unique case (modeQ)
      MODE_CONC:  modeOk = !cpuMemBusy;
      MODE_BURST: modeOk = 1'b1;
      MODE_PEEK:  modeOk = !cpuMemBusy;
      default:    modeOk = trigPending;
    endcase
  end

  assign startFetch = (state == ST_IDLE) && enQ && goQ && !pause && !hwClear && crcEn && modeOk;

  // register fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      goQ      <= 1'b0;
      intModeQ <= 1'b0;
      modeQ    <= MODE_CONC;
      abortQ   <= 1'b1;
    end else begin
      abortQ <= abortNow;
      if (ctrlWr) begin
        enQ      <= ctrlWrData[EN_BIT];
        goQ      <= ctrlWrData[GO_BIT] && !abortNow;
        intModeQ <= ctrlWrData[IM_BIT];
        modeQ    <= scanMode_e'(ctrlWrData[MODE_LSB +: 2]);
      end else if (hwClear) begin
        goQ <= 1'b0;
      end
    end
  end

  // trigger edge capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigQ       <= 1'b0;
      trigPending <= 1'b0;
    end else begin
      trigQ       <= trigIn;
      trigPending <= goQ && ((trigPending && !startFetch) || (trigIn && !trigQ));
    end
  end

  // fetch sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (startFetch) state <= ST_REQ;
        ST_REQ:  if (memReq && memGnt) state <= ST_SEND;
        ST_SEND: if (crcReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq          = (state == ST_REQ) && !((modeQ == MODE_PEEK) && cpuMemBusy);
  assign crcValid        = (state == ST_SEND);
  assign strobe.loadWord = (state == ST_REQ) && memReq && memGnt;
  assign strobe.advance  = (state == ST_SEND) && crcReady;
  assign busy            = goQ || (state != ST_IDLE);

  always_comb begin
    unique case (modeQ)
      MODE_BURST: begin
        cpuStall = enQ && goQ && !pause;
        irqHold  = !intModeQ && irqPending && goQ;
      end
      MODE_PEEK: begin
        cpuStall = 1'b0;
        irqHold  = 1'b0;
      end
      default: begin
        cpuStall = (state == ST_REQ);
        irqHold  = !intModeQ && irqPending && (state == ST_REQ);
      end
    endcase
  end

  assign ctrlRd = {abortQ, busy, enQ, goQ, intModeQ, modeQ};

  // R5
  crcgo_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goQ && !crcGo) |=> !goQ);

  // R4
  go_needs_crc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goQ) |-> $past(crcEn && crcGo && !lowInvalid));

  // R8
  peek_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && cpuMemBusy) |-> (modeQ != MODE_PEEK));

  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && pause) |=> (state == ST_IDLE));

  // R13
  crc_valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (crcValid && !crcReady) |=> crcValid);
endmodule

// File: rtl/memScanner.sv
module memScanner
  import scanPkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int MEM_WORDS = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWr,
  input  logic [CTRL_WR_W-1:0] ctrlWrData,
  input  logic                 lowWr,
  input  logic                 highWr,
  input  logic [AW-1:0]        addrWrData,
  output logic [CTRL_RD_W-1:0] ctrlRd,
  output logic [AW-1:0]        lowAddrRd,
  output logic [AW-1:0]        highAddrRd,
  input  logic                 crcEn,
  input  logic                 crcGo,
  input  logic                 trigIn,
  output logic                 memReq,
  output logic [AW-1:0]        memAddr,
  input  logic                 memGnt,
  input  logic [DW-1:0]        memRdata,
  input  logic                 cpuMemBusy,
  output logic                 cpuStall,
  input  logic                 irqPending,
  input  logic                 irqInService,
  output logic                 irqHold,
  output logic                 crcValid,
  output logic [DW-1:0]        crcData,
  input  logic                 crcReady
);
  scanStrobe_t strobe;
  logic        lowGtHigh, lowInvalid;
  logic [AW-1:0] lowAddr, highAddr;

  scanCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .crcEn(crcEn), .crcGo(crcGo), .trigIn(trigIn), .cpuMemBusy(cpuMemBusy),
    .irqPending(irqPending), .irqInService(irqInService), .memGnt(memGnt),
    .crcReady(crcReady), .lowGtHigh(lowGtHigh), .lowInvalid(lowInvalid),
    .ctrlRd(ctrlRd), .memReq(memReq), .cpuStall(cpuStall), .irqHold(irqHold),
    .crcValid(crcValid), .strobe(strobe)
  );

  scanDatapath #(.AW(AW), .DW(DW), .MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lowWr(lowWr), .highWr(highWr),
    .addrWrData(addrWrData), .memRdata(memRdata), .lowAddr(lowAddr),
    .highAddr(highAddr), .wordQ(crcData), .lowGtHigh(lowGtHigh),
    .lowInvalid(lowInvalid)
  );

  assign lowAddrRd  = lowAddr;
  assign highAddrRd = highAddr;
  assign memAddr    = lowAddr;

  // R13
  crc_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (crcValid && !crcReady) |=> $stable(crcData) && $stable(lowAddr));

  // R6
  conc_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[1:0] == MODE_CONC) |-> (cpuStall == memReq));
endmodule

// File: tb/memScanner_tb.sv
`timescale 1ns/1ps
module memScanner_tb;
  localparam int AW = 8, DW = 16, MW = 200;
  localparam real CLK_NS = 8.0;

  logic clk = 0, rstN = 0;
  logic ctrlWr = 0, lowWr = 0, highWr = 0;
  logic [4:0] ctrlWrData = '0;
  logic [AW-1:0] addrWrData = '0;
  logic [6:0] ctrlRd;
  logic [AW-1:0] lowAddrRd, highAddrRd, memAddr;
  logic crcEn = 0, crcGo = 0, trigIn = 0;
  logic memReq, memGnt, cpuStall, irqHold, crcValid;
  logic [DW-1:0] memRdata, crcData;
  logic cpuMemBusy = 0, irqPending = 0, irqInService = 0, crcReady = 1;

  int total = 0, fails = 0, wordCount = 0, expAddr = 0, cyc = 0;
  logic [1:0] modeVar = 0;
  logic imVar = 0, patOn = 0, finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  assign memGnt   = memReq;
  assign memRdata = memWord(memAddr);

  memScanner #(.AW(AW), .DW(DW), .MEM_WORDS(MW)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (crcValid && crcReady) begin
        check(crcData == memWord(AW'(expAddr)), "R3 word", crcData, memWord(AW'(expAddr)));
        expAddr++;
        wordCount++;
      end
      if (modeVar == 2'b10) begin
        check(!cpuStall && !irqHold, "R8 peek stall/hold", {cpuStall, irqHold}, 0);
        check(!(memReq && cpuMemBusy), "R8 peek req", memReq, 0);
      end else if (modeVar != 2'b01) begin
        check(cpuStall == memReq, "R6 stall", cpuStall, memReq);
        check(irqHold == (irqPending && memReq && !imVar), "R11 hold", irqHold,
              irqPending && memReq && !imVar);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (patOn) cpuMemBusy = (cyc % 3 == 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeCtrl(input bit en, input bit go, input bit im, input logic [1:0] md);
    ctrlWr = 1; ctrlWrData = {en, go, im, md};
    @(posedge clk); #1;
    ctrlWr = 0; modeVar = md; imVar = im;
  endtask

  task automatic writePtrs(input int lo, input int hi);
    lowWr = 1; addrWrData = AW'(lo);
    @(posedge clk); #1;
    lowWr = 0; highWr = 1; addrWrData = AW'(hi);
    @(posedge clk); #1;
    highWr = 0;
    expAddr = lo; wordCount = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!ctrlRd[5]) break;
    end
    tick(1);
  endtask

  task automatic runScan(input logic [1:0] md, input int lo, input int hi);
    int n;
    n = (lo > hi) ? 0 : hi - lo + 1;
    writePtrs(lo, hi);
    writeCtrl(1, 1, 0, md);
    waitIdle();
    check(wordCount == n, "R3 count", wordCount, n);
    check(int'(lowAddrRd) == ((lo > hi) ? lo : hi + 1), "R3 low end", lowAddrRd,
          (lo > hi) ? lo : hi + 1);
    check(!ctrlRd[3] && !ctrlRd[5], "R3 go/busy clear", ctrlRd, 0);
  endtask

  initial begin
    int lows[4], highs[4], snapWc, snapLow;
    lows  = '{0, 3, 9, 190};
    highs = '{0, 7, 8, 199};
    tick(4);
    @(negedge clk);
    // R1
    check(ctrlRd == 7'h40, "R1 reset ctrl", ctrlRd, 7'h40);
    check(!memReq && !crcValid && !cpuStall, "R1 reset outs", {memReq, crcValid, cpuStall}, 0);
    rstN = 1; crcEn = 1; crcGo = 1;
    tick(3);
    // R4 abort clears once CRC is up
    check(!ctrlRd[6], "R4 abort low", ctrlRd[6], 0);
    // R2 field layout
    writeCtrl(1, 0, 1, 2'b10);
    @(negedge clk);
    check(ctrlRd == 7'h16, "R2 layout", ctrlRd, 7'h16);
    writeCtrl(0, 0, 0, 2'b00);

    // R3/R6/R8 sweep over modes and ranges
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 4; r++) begin
        patOn = (m != 1);
        runScan(2'(m), lows[r], highs[r]);
      end
    end
    patOn = 0; cpuMemBusy = 0;

    // R6/R8 CPU permanently busy: no fetch in concurrent or peek
    for (int m = 0; m < 3; m += 2) begin
      cpuMemBusy = 1;
      writePtrs(10, 12);
      writeCtrl(1, 1, 0, 2'(m));
      tick(20);
      check(wordCount == 0 && lowAddrRd == 10, m == 0 ? "R6 busy cpu" : "R8 busy cpu",
            wordCount, 0);
      cpuMemBusy = 0;
      waitIdle();
      check(wordCount == 3, m == 0 ? "R6 resume" : "R8 resume", wordCount, 3);
    end

    // R7 burst ignores CPU and stalls it
    cpuMemBusy = 1;
    writePtrs(30, 60);
    writeCtrl(1, 1, 0, 2'b01);
    tick(10);
    @(negedge clk);
    check(cpuStall == 1, "R7 stall", cpuStall, 1);
    check(wordCount > 0, "R7 progress", wordCount, 1);
    waitIdle();
    check(wordCount == 31 && !cpuStall, "R7 done", wordCount, 31);
    cpuMemBusy = 0;

    // R4 refusal without CRC enable
    crcEn = 0;
    writePtrs(4, 6);
    tick(2);
    check(ctrlRd[6] == 1, "R4 abort crc off", ctrlRd[6], 1);
    writeCtrl(1, 1, 0, 2'b01);
    tick(10);
    check(!ctrlRd[3] && wordCount == 0, "R4 go refused", ctrlRd, 0);
    crcEn = 1;
    // R4 refusal with invalid low pointer
    writePtrs(210, 220);
    tick(2);
    check(ctrlRd[6] == 1, "R4 abort bad addr", ctrlRd[6], 1);
    writeCtrl(1, 1, 0, 2'b01);
    tick(10);
    check(!ctrlRd[3] && wordCount == 0, "R4 bad addr refused", ctrlRd, 0);

    // R5 CRC go drop
    writePtrs(0, 100);
    writeCtrl(1, 1, 0, 2'b01);
    tick(15);
    crcGo = 0;
    tick(5);
    snapWc = wordCount;
    check(!ctrlRd[3] && !ctrlRd[5], "R5 go cleared", ctrlRd, 0);
    tick(10);
    check(wordCount == snapWc, "R5 no fetch", wordCount, snapWc);
    crcGo = 1;
    tick(2);

    // R9 trigger mode
    writePtrs(20, 29);
    writeCtrl(1, 1, 0, 2'b11);
    tick(10);
    check(wordCount == 0, "R9 no edge", wordCount, 0);
    for (int k = 1; k <= 3; k++) begin
      trigIn = 1; tick(2);
      trigIn = 0; tick(8);
      check(wordCount == k, "R9 one per edge", wordCount, k);
    end
    writeCtrl(1, 0, 0, 2'b11);
    tick(2);
    check(!ctrlRd[3] && lowAddrRd == 23, "R9 stop", lowAddrRd, 23);

    // R10 scanning paused during interrupt service
    irqInService = 1;
    writePtrs(40, 44);
    writeCtrl(1, 1, 1, 2'b01);
    tick(15);
    check(wordCount == 0 && lowAddrRd == 40 && !cpuStall, "R10 paused", wordCount, 0);
    irqInService = 0;
    waitIdle();
    check(wordCount == 5, "R10 resumed", wordCount, 5);

    // R11 burst holds interrupts while go
    irqPending = 1;
    writePtrs(50, 70);
    writeCtrl(1, 1, 0, 2'b01);
    tick(6);
    @(negedge clk);
    check(irqHold == 1, "R11 burst hold", irqHold, 1);
    waitIdle();
    check(irqHold == 0, "R11 burst release", irqHold, 0);
    // R11 concurrent holds only during requests (monitor checks relation)
    runScan(2'b00, 71, 80);
    irqPending = 0;

    // R12 enable clear pauses, keeps fields
    writePtrs(100, 140);
    writeCtrl(1, 1, 0, 2'b01);
    tick(12);
    writeCtrl(0, 1, 0, 2'b01);
    tick(4);
    snapWc = wordCount; snapLow = lowAddrRd;
    tick(10);
    check(wordCount == snapWc && int'(lowAddrRd) == snapLow, "R12 paused", wordCount, snapWc);
    check(ctrlRd == 7'h29 && highAddrRd == 140, "R12 fields kept", ctrlRd, 7'h29);
    writeCtrl(1, 1, 0, 2'b01);
    waitIdle();
    check(wordCount == 41, "R12 resumed", wordCount, 41);

    // R13 CRC back-pressure
    crcReady = 0;
    writePtrs(150, 155);
    writeCtrl(1, 1, 0, 2'b01);
    tick(10);
    check(crcValid && crcData == memWord(150) && lowAddrRd == 150, "R13 held", crcData, memWord(150));
    tick(3);
    check(crcValid && crcData == memWord(150) && lowAddrRd == 150, "R13 still held", crcData, memWord(150));
    crcReady = 1;
    waitIdle();
    check(wordCount == 6, "R13 drained", wordCount, 6);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule